// File: doc/BRIEF.md
# Variable-Length Synchronous Serial Transmitter

This block sends words of 8 to 16 bits over a serial clock and data pair. Software programs it through a small word-wide register port. The port holds a control word, a length code, a 16-bit holding register and a status word. Data written to the holding register is copied into a shift register as soon as that shifter has nothing left to send and transmission is enabled. A new word written while a frame is still going out therefore follows that frame with no idle time. This allows continuous streaming with one word of buffering.

The frame length comes from a 4-bit code and is captured when each frame loads. The bit order is either most-significant first or least-significant first, and is also captured at load. The length code can only be changed while both enable bits are clear. Codes outside the legal set are dropped. The serial clock idles high. During a frame, each bit occupies one serial clock period: the clock is low for the first half and high for the second half.

Top module: `sstx_top`

## Requirements
- R1: After reset the control word reads 0, the length register reads 16'hFFF0 (16 bits), the status shows busy 0 and holding empty 1, and both sclk_o and sdata_o are 1.
- R2: Length code 4'b0000 sends 16 bits per frame, and codes 4'b1000 to 4'b1111 send 8 to 15 bits. Each frame has exactly that many sclk_o rising edges.
- R3: A write to the length register (address 1, bits 3:0) with a code from 4'b0001 to 4'b0111 is ignored, and the previous code is kept.
- R4: A write to the length register is ignored while tx enable (control bit 0) or rx enable (control bit 1) is 1.
- R5: Bits 15:4 of the length register always read as 1.
- R6: A write to the holding register (address 2) drives hold_empty_o low after that clock edge. If tx is enabled and no frame is active, the next edge moves the word into the shifter: hold_empty_o returns high and busy_o goes high.
- R7: A word that is pending when a frame's last bit ends loads at that same edge. busy_o stays high and the sclk_o rising edges keep the same spacing of 2*HALF_CYC cycles across the frame boundary.
- R8: Only the lowest N bits of the word are sent. With control bit 2 clear, bit N-1 goes first. With control bit 2 set, bit 0 goes first.
- R9: While control bit 2 is 1, reading the holding register returns the stored word with all 16 bits in reverse order.
- R10: During a frame, sclk_o is low for HALF_CYC cycles and then high for HALF_CYC cycles per bit. sdata_o changes only as the clock goes low. Between frames, sclk_o and sdata_o are 1.
- R11: While tx enable is 0, a written word stays pending (hold_empty_o 0, busy_o 0, sclk_o 1) and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 length, 2 holding, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data, idles high |
| busy_o | output | 1 | A frame is shifting |
| hold_empty_o | output | 1 | Holding register has no pending word |

## Verification
The hardest situation to reach is a word landing in the holding register while a frame is still shifting. The handover at the last bit edge has to happen without a lost cycle, across a change of length and bit order between streams. The stimulus draws random legal lengths and bit orders. For each setting it writes a burst of random words, each one placed as soon as hold_empty_o rises, so that every frame boundary after the first is a gapless reload. A monitor checks every received bit against a predicted stream and checks the spacing of sclk_o rising edges across each boundary.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
   localparam int CODE_W = 4;
   localparam int LEN_W  = 5;

   typedef enum logic [1:0] {
      ADR_CTRL = 2'd0,
      ADR_LEN  = 2'd1,
      ADR_HOLD = 2'd2,
      ADR_STAT = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic lsb_first;
      logic rx_en;
      logic tx_en;
   } ctrl_t;

   function automatic logic code_ok(input logic [CODE_W-1:0] c);
      return (c == '0) || c[CODE_W-1];
   endfunction

   function automatic logic [LEN_W-1:0] code_len(input logic [CODE_W-1:0] c);
      return c[CODE_W-1] ? {2'b01, c[CODE_W-2:0]} : LEN_W'(16);
   endfunction
endpackage

// File: rtl/sstx_regs.sv
module sstx_regs
   import sstx_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [1:0]       addr_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   input  logic             take_i,
   input  logic             busy_i,
   output ctrl_t            ctrl_o,
   output logic [LEN_W-1:0] len_o,
   output logic [DW-1:0]    hold_o,
   output logic             hold_full_o
);
   localparam int CTRL_W = $bits(ctrl_t);

   ctrl_t             ctrl_q;
   logic [CODE_W-1:0] code_q;
   logic [DW-1:0]     hold_q;
   logic              full_q;
   logic [DW-1:0]     hold_rev;
   logic              len_wr_ok;

   assign len_wr_ok = we_i && (addr_i == ADR_LEN) && !ctrl_q.tx_en && !ctrl_q.rx_en
                      && code_ok(wdata_i[CODE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         code_q <= '0;
         hold_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (we_i && (addr_i == ADR_CTRL))
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
         if (len_wr_ok)
            code_q <= wdata_i[CODE_W-1:0];
         if (we_i && (addr_i == ADR_HOLD)) begin
            hold_q <= wdata_i;
            full_q <= 1'b1;
         end else if (take_i) begin
            full_q <= 1'b0;
         end
      end
   end

   for (genvar gi = 0; gi < DW; gi++) begin : g_rev
      assign hold_rev[gi] = hold_q[DW-1-gi];
   end

   always_comb begin
      case (addr_i)
         ADR_CTRL: rdata_o = {{(DW-CTRL_W){1'b0}}, ctrl_q};
         ADR_LEN:  rdata_o = {{(DW-CODE_W){1'b1}}, code_q};
         ADR_HOLD: rdata_o = ctrl_q.lsb_first ? hold_rev : hold_q;
         default:  rdata_o = {{(DW-2){1'b0}}, ~full_q, busy_i};
      endcase
   end

   assign ctrl_o      = ctrl_q;
   assign len_o       = code_len(code_q);
   assign hold_o      = hold_q;
   assign hold_full_o = full_q;

   p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      code_ok(code_q));
   p_len_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.tx_en || ctrl_q.rx_en) |=> $stable(code_q));
endmodule

// File: rtl/sstx_sclk_gen.sv
module sstx_sclk_gen #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic bit_end_o
);
   logic phase_q;
   logic half_done;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("sstx_sclk_gen: HALF_CYC must be at least 1");
   end

   if (HALF_CYC == 1) begin : g_fast
      assign half_done = 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      phase_q <= 1'b0;
         else if (!run_i) phase_q <= 1'b0;
         else             phase_q <= ~phase_q;
      end
   end else begin : g_count
      localparam int CW = $clog2(HALF_CYC);
      logic [CW-1:0] cnt_q;
      assign half_done = (cnt_q == CW'(HALF_CYC-1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (!run_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
         end else if (half_done) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
      p_half_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (run_i && !half_done) |=> $stable(sclk_o));
   end

   assign sclk_o    = run_i ? phase_q : 1'b1;
   assign bit_end_o = run_i && phase_q && half_done;
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
   import sstx_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en_i,
   input  logic             lsb_first_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [DW-1:0]    hold_i,
   input  logic             hold_full_i,
   input  logic             bit_end_i,
   output logic             take_o,
   output logic             busy_o,
   output logic             sdata_o
);
   logic [DW-1:0]    sh_q;
   logic [LEN_W-1:0] rem_q;
   logic             lsb_q;
   logic             busy_q;
   logic             last_bit;
   logic [DW-1:0]    load_val;

   assign last_bit = (rem_q == '0);
   assign take_o   = tx_en_i && hold_full_i && (!busy_q || (bit_end_i && last_bit));
   assign load_val = lsb_first_i ? hold_i : (hold_i << (LEN_W'(DW) - len_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rem_q  <= '0;
         lsb_q  <= 1'b0;
         busy_q <= 1'b0;
      end else if (take_o) begin
         sh_q   <= load_val;
         rem_q  <= len_i - 1'b1;
         lsb_q  <= lsb_first_i;
         busy_q <= 1'b1;
      end else if (busy_q && bit_end_i) begin
         if (last_bit) begin
            busy_q <= 1'b0;
         end else begin
            sh_q  <= lsb_q ? (sh_q >> 1) : (sh_q << 1);
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   assign busy_o  = busy_q;
   assign sdata_o = busy_q ? (lsb_q ? sh_q[0] : sh_q[DW-1]) : 1'b1;

   p_reload_gapless_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bit_end_i && last_bit && hold_full_i && tx_en_i) |=> busy_q);
   p_frame_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bit_end_i && last_bit && !(hold_full_i && tx_en_i)) |=> !busy_q);
endmodule

// File: rtl/sstx_top.sv
module sstx_top
   import sstx_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              busy_o,
   output logic              hold_empty_o
);
   if (DATA_W != 16) begin : g_bad_width
      $error("sstx_top: the length code maps to at most 16 bits; DATA_W must be 16");
   end

   ctrl_t             ctrl;
   logic [LEN_W-1:0]  len;
   logic [DATA_W-1:0] hold;
   logic              hold_full;
   logic              take;
   logic              busy;
   logic              bit_end;

   sstx_regs #(.DW(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .take_i(take), .busy_i(busy),
      .ctrl_o(ctrl), .len_o(len), .hold_o(hold), .hold_full_o(hold_full)
   );

   sstx_sclk_gen #(.HALF_CYC(HALF_CYC)) sclk_i (
      .clk(clk), .rst_n(rst_n), .run_i(busy), .sclk_o(sclk_o), .bit_end_o(bit_end)
   );

   sstx_shifter #(.DW(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .tx_en_i(ctrl.tx_en), .lsb_first_i(ctrl.lsb_first),
      .len_i(len), .hold_i(hold), .hold_full_i(hold_full), .bit_end_i(bit_end),
      .take_o(take), .busy_o(busy), .sdata_o(sdata_o)
   );

   assign busy_o       = busy;
   assign hold_empty_o = ~hold_full;

   p_take_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !(reg_we && reg_addr == ADR_HOLD)) |=> (hold_empty_o && busy_o));
endmodule

// File: tb/sstx_top_tb_top.sv
module sstx_top_tb_top;
   localparam int HALF = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        sclk_o, sdata_o, busy_o, hold_empty_o;

   int n_chk = 0;
   int n_fail = 0;
   bit exp_bits [0:8191];
   int wr_idx = 0;
   int rd_idx = 0;
   longint cyc = 0;
   longint last_rise = 0;
   bit busy_cont = 0;
   logic prev_sclk = 1'b1;
   bit done = 0;

   always #4 clk = ~clk;

   sstx_top #(.DATA_W(16), .HALF_CYC(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o),
      .sdata_o(sdata_o), .busy_o(busy_o), .hold_empty_o(hold_empty_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int code_to_len(input logic [3:0] c);
      return c[3] ? 8 + int'(c[2:0]) : 16;
   endfunction

   function automatic logic [15:0] rev16(input logic [15:0] d);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = d[15-i];
      return r;
   endfunction

   task automatic push_frame(input logic [15:0] d, input int n, input bit lsb);
      for (int i = 0; i < n; i++) begin
         exp_bits[wr_idx] = lsb ? d[i] : d[n-1-i];
         wr_idx++;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy_o || !hold_empty_o) @(negedge clk);
   endtask

   // serial monitor: bit stream (R8, R2) and clock spacing (R7, R10)
   always @(negedge clk) begin
      cyc++;
      if (!busy_o) begin
         busy_cont = 0;
         if (!(sclk_o && sdata_o)) chk(0, "R10 idle lines", {sclk_o, sdata_o}, 2'b11);
      end
      if (!prev_sclk && sclk_o) begin
         if (rd_idx >= wr_idx) chk(0, "R2 extra sclk edge", rd_idx, wr_idx);
         else begin
            chk(sdata_o == exp_bits[rd_idx], "R8 serial bit", sdata_o, exp_bits[rd_idx]);
            rd_idx++;
         end
         if (busy_cont)
            chk(cyc - last_rise == 2*HALF, "R7 R10 sclk spacing", cyc - last_rise, 2*HALF);
         last_rise = cyc;
         busy_cont = 1;
      end
      prev_sclk = sclk_o;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      void'($urandom(32'h5EED_0417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, r); chk(r == 16'h0, "R1 ctrl", r, 16'h0);
      rd(2'd1, r); chk(r == 16'hFFF0, "R1 length", r, 16'hFFF0);
      rd(2'd3, r); chk(r == 16'h2, "R1 status", r, 16'h2);
      chk(sclk_o && sdata_o && !busy_o && hold_empty_o, "R1 pins",
          {sclk_o, sdata_o, busy_o, hold_empty_o}, 4'b1101);

      // R3 invalid code ignored, R5 upper ones
      wr(2'd1, 16'h000A);
      wr(2'd1, 16'h0003);
      rd(2'd1, r); chk(r == 16'hFFFA, "R3 invalid code kept", r, 16'hFFFA);
      wr(2'd1, 16'h0000);
      rd(2'd1, r); chk(r == 16'hFFF0, "R5 upper bits", r, 16'hFFF0);
      wr(2'd1, 16'h000A);

      // R4 locked while enabled
      wr(2'd0, 16'h0001); wr(2'd1, 16'h000C);
      rd(2'd1, r); chk(r == 16'hFFFA, "R4 tx_en lock", r, 16'hFFFA);
      wait_idle();
      wr(2'd0, 16'h0002); wr(2'd1, 16'h000C);
      rd(2'd1, r); chk(r == 16'hFFFA, "R4 rx_en lock", r, 16'hFFFA);
      wr(2'd0, 16'h0000); wr(2'd1, 16'h0008);

      // R11 pending while disabled
      wr(2'd2, 16'hA5C3);
      repeat (10) @(negedge clk);
      chk(!busy_o && !hold_empty_o && sclk_o, "R11 pending",
          {busy_o, hold_empty_o, sclk_o}, 3'b001);
      push_frame(16'hA5C3, 8, 0);
      wr(2'd0, 16'h0001);
      wait_idle();

      // R6 handover timing
      wr(2'd2, 16'h3C96);
      push_frame(16'h3C96, 8, 0);
      chk(!hold_empty_o && !busy_o, "R6 after write", {hold_empty_o, busy_o}, 2'b00);
      @(negedge clk);
      chk(hold_empty_o && busy_o && !sclk_o, "R6 after load",
          {hold_empty_o, busy_o, sclk_o}, 3'b110);
      wait_idle();

      // R9 reversed readback
      wr(2'd0, 16'h0004); wr(2'd2, 16'h1234);
      rd(2'd2, r); chk(r == rev16(16'h1234), "R9 reversed read", r, rev16(16'h1234));
      wr(2'd0, 16'h0000);
      rd(2'd2, r); chk(r == 16'h1234, "R9 plain read", r, 16'h1234);
      wr(2'd0, 16'h0004);
      push_frame(16'h1234, 8, 1);
      wr(2'd0, 16'h0005);
      wait_idle();

      // random streams: R2 R7 R8 R9
      for (int k = 0; k < 14; k++) begin
         int sel, n, nw;
         logic [3:0] code;
         bit lsb;
         sel = int'($urandom % 9);
         code = (sel == 8) ? 4'h0 : 4'(8 + sel);
         if (k == 0) code = 4'h0;
         if (k == 1) code = 4'h8;
         if (k == 2) code = 4'hF;
         lsb = bit'($urandom % 2);
         n = code_to_len(code);
         wr(2'd0, 16'h0000);
         wr(2'd1, {12'h0, code});
         rd(2'd1, r); chk(r == {12'hFFF, code}, "R2 R5 length read", r, {12'hFFF, code});
         wr(2'd0, {13'h0, lsb, 2'b01});
         nw = 2 + int'($urandom % 4);
         for (int w = 0; w < nw; w++) begin
            logic [15:0] d;
            d = 16'($urandom);
            @(negedge clk);
            while (!hold_empty_o) @(negedge clk);
            push_frame(d, n, lsb);
            wr(2'd2, d);
            if (lsb) begin
               rd(2'd2, r); chk(r == rev16(d), "R9 stream read", r, rev16(d));
            end
         end
         wait_idle();
      end

      repeat (8) @(negedge clk);
      chk(rd_idx == wr_idx, "R2 all bits sent", rd_idx, wr_idx);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule